// File: doc/BRIEF.md
# Synchronized DMA Request Router Channel

This block is a single output channel of a DMA request line multiplexer. A 7-bit selector picks one of up to 127 peripheral request lines and routes it to one DMA controller channel. The DMA controller acknowledges a request by letting the request line fall, and the channel counts each of those falls as a served request.

Forwarding can be made conditional on a synchronization event. The block takes one of several synchronization inputs, filters it for stability and detects the chosen edge on it. After an accepted edge, the selected request is connected to the output. A reload counter lets exactly count+1 served requests through and then disconnects the input again. When the counter reloads, the block can emit a one-cycle event pulse. An edge that arrives while the channel is still connected sets a sticky overrun flag. That flag has a write-1 clear strobe and an interrupt gated by an enable.

Configuration arrives as a set of field inputs qualified by a single write strobe. Address decoding and access filtering sit outside this block.

Top module: `drr_chan_top`

## Requirements
- R1: Selector value k in 1..NUM_REQ routes `reqIn[k-1]`. Selector value 0, or a value above NUM_REQ, keeps `reqOut` low whatever the inputs do.
- R2: While sync enable is 0, `reqOut` follows the selected input in the same cycle, with no register in the path.
- R3: While sync enable is 1, the selected request reaches `reqOut` only after an accepted sync edge that finds the selected input high. An accepted edge that finds the selected input low is discarded, and the channel stays disconnected until a later edge.
- R4: The 2-bit polarity field chooses which edges count: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none.
- R5: A new sync level must be sampled on three consecutive rising clock edges to be accepted. When the level first appears before clock edge k, the channel connects at edge k+3. A level held for only two samples is ignored.
- R6: A sync edge whose acceptance falls within the three clock cycles that follow a configuration write edge is lost.
- R7: In sync mode, after count+1 served requests (falls of the forwarded request) the input is disconnected and the counter reloads.
- R8: With event enable set, `evtPulse` is high for exactly one cycle, in the cycle after the served request that makes the counter reload. With count 0, this happens after every served request.
- R9: An accepted sync edge while the channel is connected sets `ovrFlag`. The flag holds until an `ovrClr` pulse clears it. `ovrIrq` equals the flag ANDed with the interrupt enable.
- R10: A write changes the count field only when sync enable and event enable were both 0 before that write.
- R11: While both enables are 0, the counter is held at the programmed count. With only event enable set, the request passes straight through and the counter still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | NUM_REQ | Peripheral request lines; bit k-1 is selector value k |
| syncIn | input | NUM_SYNC | Synchronization inputs |
| cfgWe | input | 1 | Configuration write strobe |
| cfgReqId | input | 7 | Request selector, 0 = none |
| cfgSyncId | input | 5 | Sync input selector |
| cfgBurst | input | 5 | Requests per burst minus one |
| cfgPol | input | 2 | Edge polarity code |
| cfgSyncEn | input | 1 | Sync gating enable |
| cfgEvtEn | input | 1 | Event pulse enable |
| cfgOvrIe | input | 1 | Overrun interrupt enable |
| ovrClr | input | 1 | Write-1 clear of the overrun flag |
| reqOut | output | 1 | Request toward the DMA channel |
| evtPulse | output | 1 | One-cycle reload event |
| ovrFlag | output | 1 | Sticky sync overrun flag |
| ovrIrq | output | 1 | Overrun interrupt |

## Verification
`reqOut` is combinational from `reqIn`, so the bench changes an input at a falling edge and samples 1 ns later. A sync level set before clock edge k takes effect at edge k+3. The bench therefore expects the output still low at the third falling edge after the change and high at the fourth. The overrun flag follows the same count. An event pulse appears after the clock edge that follows the served request's fall, and it is gone one cycle later. A write made at clock edge w masks any acceptance in the next three cycles. The bench places a sync edge so that its acceptance lands inside that window.

// File: rtl/drr_pkg.sv
package drr_pkg;
  localparam int ID_W  = 7;
  localparam int SID_W = 5;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_RISE = 2'b01,
    POL_FALL = 2'b10,
    POL_BOTH = 2'b11
  } pol_e;

  typedef struct packed {
    logic [ID_W-1:0]  reqId;
    logic [SID_W-1:0] syncId;
    logic [CNT_W-1:0] burst;
    pol_e             pol;
    logic             syncEn;
    logic             evtEn;
    logic             ovrIe;
  } cfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic gateOpen;
    logic gateClose;
    logic evtFire;
    logic ovrSet;
  } ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic syncRise;
    logic syncFall;
    logic served;
    logic cntZero;
    logic gateIsOpen;
    logic selPending;
  } sts_t;
endpackage

// File: rtl/drr_ctrl.sv
module drr_ctrl
  import drr_pkg::*;
#(
  parameter int MASK_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             wrCfg,
  input  logic             cfgWe,
  input  sts_t             sts,
  output ctl_t             ctl,
  output logic [ID_W-1:0]  reqIdQ,
  output logic [SID_W-1:0] syncIdQ,
  output logic [CNT_W-1:0] burstQ,
  output logic             syncEnQ,
  output logic             ovrIeQ,
  output logic [CNT_W-1:0] reloadVal
);
  localparam int MW = $clog2(MASK_LEN + 1);

  cfg_t          cfgQ;
  cfg_t          cfgNext;
  logic [MW-1:0] maskCnt;
  logic          active;
  logic          wantRise;
  logic          wantFall;
  logic          syncEvt;
  logic          underrun;

  always_comb begin
    active  = cfgQ.syncEn | cfgQ.evtEn;
    cfgNext = wrCfg;
    if (active) cfgNext.burst = cfgQ.burst;   // count locked while enabled
    reloadVal = cfgWe ? cfgNext.burst : cfgQ.burst;
    wantRise  = (cfgQ.pol == POL_RISE) || (cfgQ.pol == POL_BOTH);
    wantFall  = (cfgQ.pol == POL_FALL) || (cfgQ.pol == POL_BOTH);
    syncEvt   = (maskCnt == '0) &&
                ((wantRise && sts.syncRise) || (wantFall && sts.syncFall));
    underrun  = sts.served && sts.cntZero;

    ctl.cntLoad   = !active || underrun;
    ctl.cntDec    = active && sts.served && !sts.cntZero;
    ctl.evtFire   = cfgQ.evtEn && underrun;
    ctl.gateClose = !cfgQ.syncEn || underrun;
    ctl.gateOpen  = cfgQ.syncEn && syncEvt && !sts.gateIsOpen && sts.selPending;
    ctl.ovrSet    = cfgQ.syncEn && syncEvt && sts.gateIsOpen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      maskCnt <= '0;
    end else begin
      if (cfgWe) cfgQ <= cfgNext;
      if (cfgWe)               maskCnt <= MW'(MASK_LEN);
      else if (maskCnt != '0)  maskCnt <= maskCnt - 1'b1;
    end
  end

  assign reqIdQ  = cfgQ.reqId;
  assign syncIdQ = cfgQ.syncId;
  assign burstQ  = cfgQ.burst;
  assign syncEnQ = cfgQ.syncEn;
  assign ovrIeQ  = cfgQ.ovrIe;

  // R10: count field frozen while either enable is set
  a_r10_burst_locked: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.syncEn || cfgQ.evtEn) |=> $stable(cfgQ.burst));

  // R6: nothing is opened or flagged in the cycle right after a write
  a_r6_mask_after_write: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (!ctl.gateOpen && !ctl.ovrSet));

  // R3: opening only happens with sync enabled
  a_r3_open_needs_sync: assert property (@(posedge clk) disable iff (!rstN)
    ctl.gateOpen |-> cfgQ.syncEn);
endmodule

// File: rtl/drr_dpath.sv
module drr_dpath
  import drr_pkg::*;
#(
  parameter int NUM_REQ  = 127,
  parameter int NUM_SYNC = 23,
  parameter int FILT_LEN = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REQ-1:0]  reqIn,
  input  logic [NUM_SYNC-1:0] syncIn,
  input  logic [ID_W-1:0]     reqId,
  input  logic [SID_W-1:0]    syncId,
  input  logic [CNT_W-1:0]    burst,
  input  logic                syncEn,
  input  logic                ovrIe,
  input  ctl_t                ctl,
  input  logic [CNT_W-1:0]    reloadVal,
  input  logic                ovrClr,
  output sts_t                sts,
  output logic                reqOut,
  output logic                evtPulse,
  output logic                ovrFlag,
  output logic                ovrIrq
);
  localparam int REQ_SPAN  = 1 << ID_W;
  localparam int SYNC_SPAN = 1 << SID_W;

  logic [REQ_SPAN-1:0]  reqPad;
  logic [SYNC_SPAN-1:0] syncPad;
  logic                 selReq;
  logic                 syncRaw;
  logic [FILT_LEN-1:0]  hist;
  logic                 fLvl;
  logic                 settled;
  logic [CNT_W-1:0]     cnt;
  logic                 gateOpen;
  logic                 prevOut;
  logic                 evtQ;
  logic                 ovrQ;

  // index 0 and out-of-range selectors land on zero bits
  assign reqPad  = REQ_SPAN'({reqIn, 1'b0});
  assign syncPad = SYNC_SPAN'(syncIn);
  assign selReq  = reqPad[reqId];
  assign syncRaw = syncPad[syncId];

  generate
    if (FILT_LEN > 1) begin : g_hist
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) hist <= '0;
        else       hist <= {hist[FILT_LEN-2:0], syncRaw};
    end else begin : g_hist1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) hist <= '0;
        else       hist <= syncRaw;
    end
  endgenerate

  assign settled = (&hist) || (~|hist);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fLvl     <= 1'b0;
      cnt      <= '0;
      gateOpen <= 1'b0;
      prevOut  <= 1'b0;
      evtQ     <= 1'b0;
      ovrQ     <= 1'b0;
    end else begin
      if (settled) fLvl <= hist[0];
      if (ctl.cntLoad)     cnt <= reloadVal;
      else if (ctl.cntDec) cnt <= cnt - 1'b1;
      if (ctl.gateClose)     gateOpen <= 1'b0;
      else if (ctl.gateOpen) gateOpen <= 1'b1;
      prevOut <= reqOut;
      evtQ    <= ctl.evtFire;
      if (ctl.ovrSet)   ovrQ <= 1'b1;
      else if (ovrClr)  ovrQ <= 1'b0;
    end
  end

  assign reqOut   = selReq & (~syncEn | gateOpen);
  assign evtPulse = evtQ;
  assign ovrFlag  = ovrQ;
  assign ovrIrq   = ovrQ & ovrIe;

  always_comb begin
    sts.syncRise   = settled &  hist[0] & ~fLvl;
    sts.syncFall   = settled & ~hist[0] &  fLvl;
    sts.served     = prevOut & ~selReq;
    sts.cntZero    = (cnt == '0);
    sts.gateIsOpen = gateOpen;
    sts.selPending = selReq;
  end

  // R1: null selector never forwards
  a_r1_null_id: assert property (@(posedge clk) disable iff (!rstN)
    (reqId == '0) |-> !reqOut);

  // R8: event is a single-cycle pulse
  a_r8_evt_single: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse);

  // R9: overrun flag is sticky until cleared
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovrQ && !ovrClr) |=> ovrQ);

  // R7: down-counter never exceeds the programmed count
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= burst);

  // R3: connection only opens onto a pending request
  a_r3_open_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOpen) |-> $past(selReq));
endmodule

// File: rtl/drr_chan_top.sv
module drr_chan_top
  import drr_pkg::*;
#(
  parameter int NUM_REQ  = 127,
  parameter int NUM_SYNC = 23,
  parameter int FILT_LEN = 3,
  parameter int MASK_LEN = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REQ-1:0]  reqIn,
  input  logic [NUM_SYNC-1:0] syncIn,
  input  logic                cfgWe,
  input  logic [ID_W-1:0]     cfgReqId,
  input  logic [SID_W-1:0]    cfgSyncId,
  input  logic [CNT_W-1:0]    cfgBurst,
  input  logic [1:0]          cfgPol,
  input  logic                cfgSyncEn,
  input  logic                cfgEvtEn,
  input  logic                cfgOvrIe,
  input  logic                ovrClr,
  output logic                reqOut,
  output logic                evtPulse,
  output logic                ovrFlag,
  output logic                ovrIrq
);
  cfg_t             wrCfg;
  ctl_t             ctl;
  sts_t             sts;
  logic [ID_W-1:0]  reqIdQ;
  logic [SID_W-1:0] syncIdQ;
  logic [CNT_W-1:0] burstQ;
  logic [CNT_W-1:0] reloadVal;
  logic             syncEnQ;
  logic             ovrIeQ;

  always_comb begin
    wrCfg.reqId  = cfgReqId;
    wrCfg.syncId = cfgSyncId;
    wrCfg.burst  = cfgBurst;
    wrCfg.pol    = pol_e'(cfgPol);
    wrCfg.syncEn = cfgSyncEn;
    wrCfg.evtEn  = cfgEvtEn;
    wrCfg.ovrIe  = cfgOvrIe;
  end

  drr_ctrl #(.MASK_LEN(MASK_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .wrCfg(wrCfg), .cfgWe(cfgWe), .sts(sts),
    .ctl(ctl), .reqIdQ(reqIdQ), .syncIdQ(syncIdQ), .burstQ(burstQ),
    .syncEnQ(syncEnQ), .ovrIeQ(ovrIeQ), .reloadVal(reloadVal)
  );

  drr_dpath #(.NUM_REQ(NUM_REQ), .NUM_SYNC(NUM_SYNC), .FILT_LEN(FILT_LEN)) uDpath (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .syncIn(syncIn),
    .reqId(reqIdQ), .syncId(syncIdQ), .burst(burstQ), .syncEn(syncEnQ),
    .ovrIe(ovrIeQ), .ctl(ctl), .reloadVal(reloadVal), .ovrClr(ovrClr),
    .sts(sts), .reqOut(reqOut), .evtPulse(evtPulse), .ovrFlag(ovrFlag),
    .ovrIrq(ovrIrq)
  );
endmodule

// File: tb/tb_drr_chan_top.sv
`timescale 1ns/1ps
module tb_drr_chan_top;
  localparam int NREQ  = 127;
  localparam int NSYNC = 23;
  localparam int RID   = 5;
  localparam int SID   = 7;

  logic             clk = 1'b0;
  logic             rstN;
  logic [NREQ-1:0]  reqIn;
  logic [NSYNC-1:0] syncIn;
  logic             cfgWe;
  logic [6:0]       cfgReqId;
  logic [4:0]       cfgSyncId;
  logic [4:0]       cfgBurst;
  logic [1:0]       cfgPol;
  logic             cfgSyncEn, cfgEvtEn, cfgOvrIe, ovrClr;
  logic             reqOut, evtPulse, ovrFlag, ovrIrq;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  drr_chan_top dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .syncIn(syncIn), .cfgWe(cfgWe),
    .cfgReqId(cfgReqId), .cfgSyncId(cfgSyncId), .cfgBurst(cfgBurst),
    .cfgPol(cfgPol), .cfgSyncEn(cfgSyncEn), .cfgEvtEn(cfgEvtEn),
    .cfgOvrIe(cfgOvrIe), .ovrClr(ovrClr), .reqOut(reqOut),
    .evtPulse(evtPulse), .ovrFlag(ovrFlag), .ovrIrq(ovrIrq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int id, input int sid, input int burst, input int pol,
                    input bit se, input bit ege, input bit ie);
    @(negedge clk);
    cfgReqId = 7'(id); cfgSyncId = 5'(sid); cfgBurst = 5'(burst);
    cfgPol = 2'(pol); cfgSyncEn = se; cfgEvtEn = ege; cfgOvrIe = ie;
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serveOne(output logic ev);
    reqIn[RID-1] = 1'b1;
    @(negedge clk);
    reqIn[RID-1] = 1'b0;
    @(negedge clk);
    ev = evtPulse;
  endtask

  // gate open with request high: serve two (burst=1), leave request pending
  task automatic drainTwo(input string tag);
    @(negedge clk);
    reqIn[RID-1] = 1'b0; @(negedge clk);
    reqIn[RID-1] = 1'b1; @(negedge clk);
    reqIn[RID-1] = 1'b0; @(negedge clk);
    check({tag, " reload event"}, evtPulse, 1'b1);
    reqIn[RID-1] = 1'b1; #1;
    check({tag, " disconnected after count+1"}, reqOut, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic ev;
    rstN = 1'b0; reqIn = '0; syncIn = '0; cfgWe = 1'b0; cfgReqId = '0;
    cfgSyncId = '0; cfgBurst = '0; cfgPol = '0; cfgSyncEn = 1'b0;
    cfgEvtEn = 1'b0; cfgOvrIe = 1'b0; ovrClr = 1'b0;
    idle(4);
    rstN = 1'b1;
    idle(1);
    check("R1 reset reqOut", reqOut, 1'b0);
    check("R8 reset evtPulse", evtPulse, 1'b0);
    check("R9 reset ovrFlag", ovrFlag, 1'b0);
    check("R9 reset ovrIrq", ovrIrq, 1'b0);

    // R1: null selector
    wr(0, 0, 0, 0, 0, 0, 0);
    reqIn = '1; #1;
    check("R1 id zero blocks", reqOut, 1'b0);
    reqIn = '0;

    // R1 / R2: sweep every selector in passthrough mode
    for (int id = 1; id <= NREQ; id++) begin
      wr(id, 0, 0, 0, 0, 0, 0);
      reqIn = '0; reqIn[id-1] = 1'b1; #1;
      check($sformatf("R2 passthrough id %0d high", id), reqOut, 1'b1);
      reqIn = ~reqIn; #1;
      check($sformatf("R1 id %0d ignores others", id), reqOut, 1'b0);
    end
    reqIn = '0;

    // R8 / R11: event only, count 2 -> event every third served request
    wr(RID, SID, 2, 0, 0, 0, 0);
    wr(RID, SID, 2, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) begin
      serveOne(ev);
      check($sformatf("R8 evt-only serve %0d", i), ev, (i % 3) == 2);
    end
    @(negedge clk);
    check("R8 pulse lasts one cycle", evtPulse, 1'b0);

    // R10: count write ignored while event enable set
    wr(RID, SID, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      serveOne(ev);
      check($sformatf("R10 locked count serve %0d", i), ev, i == 2);
    end
    // count 0 accepted when disabled, then event each serve
    wr(RID, SID, 0, 0, 0, 0, 0);
    wr(RID, SID, 0, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      serveOne(ev);
      check($sformatf("R8 count0 serve %0d", i), ev, 1'b1);
    end

    // R11: counter reset while both enables clear
    wr(RID, SID, 2, 0, 0, 0, 0);
    wr(RID, SID, 2, 0, 0, 1, 0);
    serveOne(ev);
    check("R11 partial count", ev, 1'b0);
    wr(RID, SID, 2, 0, 0, 0, 0);
    wr(RID, SID, 2, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      serveOne(ev);
      check($sformatf("R11 restarted count serve %0d", i), ev, i == 2);
    end

    // sync mode, rising edges, count 1
    wr(RID, SID, 1, 1, 0, 0, 0);
    wr(RID, SID, 1, 1, 1, 1, 1);
    idle(4);
    reqIn[RID-1] = 1'b1; #1;
    check("R3 blocked before sync edge", reqOut, 1'b0);
    syncIn[SID] = 1'b1;
    idle(3);
    check("R5 not yet accepted at third edge", reqOut, 1'b0);
    idle(1);
    check("R5 R3 connected at fourth edge", reqOut, 1'b1);
    drainTwo("R7 first burst");

    // R3: edge with nothing pending is discarded
    reqIn[RID-1] = 1'b0;
    syncIn[SID] = 1'b0; idle(5);
    syncIn[SID] = 1'b1; idle(5);
    reqIn[RID-1] = 1'b1; idle(2);
    check("R3 edge without pending discarded", reqOut, 1'b0);

    // R5: two-sample glitch ignored
    syncIn[SID] = 1'b0; idle(5);
    syncIn[SID] = 1'b1; idle(2);
    syncIn[SID] = 1'b0; idle(6);
    check("R5 short pulse ignored", reqOut, 1'b0);

    // R4: falling only
    wr(RID, SID, 1, 2, 1, 1, 1);
    idle(4);
    syncIn[SID] = 1'b1; idle(6);
    check("R4 rise ignored under fall code", reqOut, 1'b0);
    check("R9 no flag without edge", ovrFlag, 1'b0);
    syncIn[SID] = 1'b0; idle(4);
    check("R4 fall accepted", reqOut, 1'b1);

    // R9: overrun while connected
    syncIn[SID] = 1'b1; idle(5);
    syncIn[SID] = 1'b0; idle(3);
    check("R9 flag not yet set", ovrFlag, 1'b0);
    idle(1);
    check("R9 overrun flag set", ovrFlag, 1'b1);
    check("R9 overrun irq", ovrIrq, 1'b1);
    idle(5);
    check("R9 flag sticky", ovrFlag, 1'b1);
    ovrClr = 1'b1; @(negedge clk); ovrClr = 1'b0;
    check("R9 flag cleared", ovrFlag, 1'b0);
    check("R9 irq cleared", ovrIrq, 1'b0);
    drainTwo("R7 after overrun");

    // R4: both edges
    wr(RID, SID, 1, 3, 1, 1, 0);
    idle(4);
    syncIn[SID] = 1'b1; idle(4);
    check("R4 both code rise", reqOut, 1'b1);
    drainTwo("R7 both rise");
    syncIn[SID] = 1'b0; idle(4);
    check("R4 both code fall", reqOut, 1'b1);
    drainTwo("R7 both fall");

    // R4: no-detection code
    wr(RID, SID, 1, 0, 1, 1, 0);
    idle(4);
    syncIn[SID] = 1'b1; idle(5);
    syncIn[SID] = 1'b0; idle(5);
    check("R4 none code never connects", reqOut, 1'b0);

    // R6: write masks a sync edge
    wr(RID, SID, 1, 1, 1, 1, 0);
    idle(4);
    syncIn[SID] = 1'b1;
    wr(RID, SID, 1, 1, 1, 1, 0);
    idle(5);
    check("R6 edge masked after write", reqOut, 1'b0);
    syncIn[SID] = 1'b0; idle(5);
    syncIn[SID] = 1'b1; idle(4);
    check("R6 later edge accepted", reqOut, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule